// File: doc/BRIEF.md
# Base-OR Address Relocation and Protection Unit

This block sits between a program's memory references and main memory in a multiprogrammed machine. Each reference carries a word address that is relative to the program. The block turns that address into an absolute word address and decides whether the reference is allowed. Relocation is a bitwise OR of a base value into the address, so no adder is involved. Protection covers three things: a limit on the size of the program region, a locked sub-region that only peripheral transfers may touch, and a secondary window of selectable length whose upper pages can be shut to transfers one page at a time.

The supervisor loads five control registers through a write port. That port is live only while the supervisor-mode input is high. In supervisor mode, requests also bypass every check and the address passes through unchanged. Each accepted request produces one registered response one cycle later. The response carries the absolute address, the character index, a violation flag and a two-bit cause code. A memory word holds eight 6-bit characters, so character references carry a 3-bit index alongside the word address.

Top module: `reloc_guard`

## Requirements
- R1: While reset is applied and once it is released, `resp_valid`, `resp_viol`, `resp_cause`, `resp_addr` and `resp_char` are all zero.
- R2: A request presented with `req_valid` high at a clock edge yields `resp_valid` high after that edge, for exactly one cycle per request. No response appears for a cycle in which `req_valid` is low.
- R3: For a user-mode request with `req_win` = 0, `resp_addr` equals `req_addr` OR the base register. Overlapping bits are not carried.
- R4: For a user-mode request with `req_win` = 0 and `req_addr` greater than or equal to the size register, the cause is 1 (beyond limit). The limit check takes priority over the sub-region check.
- R5: For a user-mode request with `req_win` = 0, within the size, and with lower bound ≤ `req_addr` ≤ upper bound (both ends inclusive), the cause is 2 when `req_xfer` = 0. A request with `req_xfer` = 1 is allowed there.
- R6: For a user-mode request with `req_win` = 1, `resp_addr` is `req_addr` OR the window base (window register bits 17:0). The window length is set by bits 19:18: code 0 gives 64 words, code 1 gives 512 and code 2 gives 4096. An address at or beyond the length gives cause 1.
- R7: When window length code 3 is loaded, every user-mode window request gives cause 1.
- R8: With length code 2, window register bit 20+k locks relative words 2048+512k to 2559+512k, for k = 0 to 3. A request with `req_xfer` = 1 into a locked page gives cause 3. Requests with `req_xfer` = 0, and requests to unlocked pages, are allowed.
- R9: With `sup_mode` = 1, `resp_addr` equals `req_addr` and the cause is 0, whatever the register contents.
- R10: A control write (`cfg_we` = 1) while `sup_mode` = 0 is ignored. Register selects are 0 base, 1 size (bits 18:0), 2 lower bound, 3 upper bound and 4 window. The other fields take bits 17:0 and the window takes all 24 bits.
- R11: `req_kind` is encoded as 00 word read, 01 word write, 10 character access and 11 reserved, which is treated as a word access. `resp_char` equals `req_char` for a character access and is zero otherwise.
- R12: `resp_viol` is 1 exactly when `resp_cause` is nonzero. The cause codes are 0 none, 1 beyond limit, 2 locked sub-region and 3 locked window page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_mode | input | 1 | Supervisor mode: enables control writes and bypasses checks |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | 3 | Control register select |
| cfg_wdata | input | 24 | Control register write data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 18 | User word address |
| req_kind | input | 2 | Access type |
| req_char | input | 3 | Character index within the word |
| req_xfer | input | 1 | 1 = peripheral transfer, 0 = processor |
| req_win | input | 1 | 1 = reference through the secondary window |
| resp_valid | output | 1 | Response strobe |
| resp_addr | output | 18 | Absolute word address |
| resp_char | output | 3 | Character index passed on |
| resp_viol | output | 1 | Protection violation |
| resp_cause | output | 2 | Violation cause code |

## Verification
Every response is due in the cycle after the edge that captures its request. A control write affects requests from the next edge onward. The driver applies stimulus on falling edges and places the expected result in a queue. The monitor examines the outputs on the following falling edge, which lies half a cycle after the response register has loaded, and takes expected items from the queue strictly in request order. A gap in requests is checked by confirming that the response strobe is low one falling edge after an idle cycle.

// File: rtl/reloc_pkg.sv
package reloc_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_LIMIT    = 2'd1,
    CAUSE_SUBLOCK  = 2'd2,
    CAUSE_PAGELOCK = 2'd3
  } cause_e;

  typedef enum logic [2:0] {
    SEL_BASE  = 3'd0,
    SEL_SIZE  = 3'd1,
    SEL_LOLIM = 3'd2,
    SEL_HILIM = 3'd3,
    SEL_WIN   = 3'd4
  } cfg_sel_e;

  localparam int unsigned WIN_CODE_LSB = 18;
  localparam int unsigned WIN_LOCK_LSB = 20;
  localparam logic [1:0]  KIND_CHAR    = 2'b10;

endpackage

// File: rtl/reloc_ctrl_regs.sv
module reloc_ctrl_regs
  import reloc_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W:0]   size_q,
  output logic [ADDR_W-1:0] lo_q,
  output logic [ADDR_W-1:0] hi_q,
  output logic [DATA_W-1:0] win_q
);

  logic [ADDR_W-1:0] base_d, lo_d, hi_d;
  logic [ADDR_W:0]   size_d;
  logic [DATA_W-1:0] win_d;

  always_comb begin
    base_d = base_q;
    size_d = size_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    win_d  = win_q;
    if (wr_en) begin
      unique case (wr_sel)
        SEL_BASE:  base_d = wr_data[ADDR_W-1:0];
        SEL_SIZE:  size_d = wr_data[ADDR_W:0];
        SEL_LOLIM: lo_d   = wr_data[ADDR_W-1:0];
        SEL_HILIM: hi_d   = wr_data[ADDR_W-1:0];
        SEL_WIN:   win_d  = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      win_q  <= '0;
    end else if (wr_en) begin
      base_q <= base_d;
      size_q <= size_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      win_q  <= win_d;
    end
  end

endmodule

// File: rtl/reloc_region_chk.sv
module reloc_region_chk
  import reloc_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W:0]   size,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic              xfer,
  output cause_e            cause
);

  logic beyond;
  logic in_lock;

  always_comb begin
    beyond  = ({1'b0, addr} >= size);
    in_lock = (addr >= lo) && (addr <= hi);
    if (beyond)
      cause = CAUSE_LIMIT;
    else if (in_lock && !xfer)
      cause = CAUSE_SUBLOCK;
    else
      cause = CAUSE_NONE;
  end

endmodule

// File: rtl/reloc_window_chk.sv
module reloc_window_chk
  import reloc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned DATA_W    = 24,
  parameter int unsigned NPAGES    = 4,
  parameter int unsigned MIN_LOG2  = 6,
  parameter int unsigned STEP_LOG2 = 3,
  parameter int unsigned PAGE_LOG2 = 9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] win,
  input  logic              xfer,
  output cause_e            cause
);

  localparam int unsigned PIDX_W   = $clog2(NPAGES);
  localparam int unsigned MAX_CODE = 2;
  localparam int unsigned TOP_BIT  = PAGE_LOG2 + PIDX_W;

  logic [1:0]        code;
  logic [4:0]        len_log2;
  logic              reserved;
  logic              beyond;
  logic              in_top;
  logic [PIDX_W-1:0] pidx;
  logic [NPAGES-1:0] locks;
  logic [NPAGES-1:0] page_hit;

  assign code  = win[WIN_CODE_LSB +: 2];
  assign locks = win[WIN_LOCK_LSB +: NPAGES];
  assign pidx  = addr[PAGE_LOG2 +: PIDX_W];

  always_comb begin
    reserved = (code == 2'd3);
    len_log2 = 5'(MIN_LOG2) + 5'(STEP_LOG2) * 5'(code);
    beyond   = |(addr >> len_log2);
    in_top   = (code == 2'(MAX_CODE)) && addr[TOP_BIT];
  end

  for (genvar p = 0; p < NPAGES; p++) begin : g_page
    assign page_hit[p] = in_top && (pidx == PIDX_W'(p)) && locks[p];
  end

  always_comb begin
    if (reserved || beyond)
      cause = CAUSE_LIMIT;
    else if (xfer && (|page_hit))
      cause = CAUSE_PAGELOCK;
    else
      cause = CAUSE_NONE;
  end

endmodule

// File: rtl/reloc_guard.sv
module reloc_guard
  import reloc_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 24,
  parameter int unsigned CHAR_W = 3,
  parameter int unsigned NPAGES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sup_mode,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic [CHAR_W-1:0] req_char,
  input  logic              req_xfer,
  input  logic              req_win,
  output logic              resp_valid,
  output logic [ADDR_W-1:0] resp_addr,
  output logic [CHAR_W-1:0] resp_char,
  output logic              resp_viol,
  output logic [1:0]        resp_cause
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  logic [ADDR_W-1:0] base_q, lo_q, hi_q;
  logic [ADDR_W:0]   size_q;
  logic [DATA_W-1:0] win_q;

  reloc_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
    .clk    (clk),
    .rst_n  (rst_q),
    .wr_en  (cfg_we && sup_mode),
    .wr_sel (cfg_sel),
    .wr_data(cfg_wdata),
    .base_q (base_q),
    .size_q (size_q),
    .lo_q   (lo_q),
    .hi_q   (hi_q),
    .win_q  (win_q)
  );

  cause_e reg_cause, win_cause;

  reloc_region_chk #(.ADDR_W(ADDR_W)) i_region (
    .addr (req_addr),
    .size (size_q),
    .lo   (lo_q),
    .hi   (hi_q),
    .xfer (req_xfer),
    .cause(reg_cause)
  );

  reloc_window_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NPAGES(NPAGES)) i_window (
    .addr (req_addr),
    .win  (win_q),
    .xfer (req_xfer),
    .cause(win_cause)
  );

  // next-state of the response stage
  logic [ADDR_W-1:0] reloc_base;
  logic [ADDR_W-1:0] addr_d;
  logic [CHAR_W-1:0] char_d;
  cause_e            cause_d;

  always_comb begin
    reloc_base = req_win ? win_q[ADDR_W-1:0] : base_q;
    if (sup_mode) begin
      addr_d  = req_addr;
      cause_d = CAUSE_NONE;
    end else begin
      addr_d  = req_addr | reloc_base;
      cause_d = req_win ? win_cause : reg_cause;
    end
    char_d = (req_kind == KIND_CHAR) ? req_char : '0;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) resp_valid <= 1'b0;
    else        resp_valid <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      resp_addr  <= '0;
      resp_char  <= '0;
      resp_cause <= '0;
      resp_viol  <= 1'b0;
    end else if (req_valid) begin
      resp_addr  <= addr_d;
      resp_char  <= char_d;
      resp_cause <= cause_d;
      resp_viol  <= (cause_d != CAUSE_NONE);
    end
  end

endmodule

// File: rtl/reloc_guard_chk.sv
module reloc_guard_chk #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned CHAR_W = 3
) (
  input logic              clk,
  input logic              rst_q,
  input logic              sup_mode,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_kind,
  input logic              req_xfer,
  input logic              req_win,
  input logic [ADDR_W-1:0] base_q,
  input logic [ADDR_W:0]   size_q,
  input logic [ADDR_W-1:0] lo_q,
  input logic [ADDR_W-1:0] hi_q,
  input logic [1:0]        win_code,
  input logic              resp_valid,
  input logic [ADDR_W-1:0] resp_addr,
  input logic [CHAR_W-1:0] resp_char,
  input logic              resp_viol,
  input logic [1:0]        resp_cause
);

  a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_q)
    req_valid |=> resp_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_q)
    !req_valid |=> !resp_valid);

  a_r3_or_reloc: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && !sup_mode && !req_win)
      |=> resp_addr == ($past(req_addr) | $past(base_q)));

  a_r4_limit: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && !sup_mode && !req_win && ({1'b0, req_addr} >= size_q))
      |=> resp_cause == 2'd1);

  a_r5_sublock: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && !sup_mode && !req_win && !req_xfer && ({1'b0, req_addr} < size_q)
     && (req_addr >= lo_q) && (req_addr <= hi_q))
      |=> resp_cause == 2'd2);

  a_r7_reserved_code: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && !sup_mode && req_win && (win_code == 2'd3))
      |=> resp_cause == 2'd1);

  a_r9_bypass: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && sup_mode)
      |=> (resp_addr == $past(req_addr)) && (resp_cause == 2'd0));

  a_r10_locked_regs: assert property (@(posedge clk) disable iff (!rst_q)
    !sup_mode |=> $stable(base_q) && $stable(size_q) && $stable(lo_q) && $stable(hi_q));

  a_r11_word_char: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && (req_kind != 2'b10)) |=> resp_char == '0);

  a_r12_flag: assert property (@(posedge clk) disable iff (!rst_q)
    resp_valid |-> (resp_viol == (resp_cause != 2'd0)));

endmodule

bind reloc_guard reloc_guard_chk #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W)) i_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .sup_mode  (sup_mode),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .req_kind  (req_kind),
  .req_xfer  (req_xfer),
  .req_win   (req_win),
  .base_q    (base_q),
  .size_q    (size_q),
  .lo_q      (lo_q),
  .hi_q      (hi_q),
  .win_code  (win_q[19:18]),
  .resp_valid(resp_valid),
  .resp_addr (resp_addr),
  .resp_char (resp_char),
  .resp_viol (resp_viol),
  .resp_cause(resp_cause)
);

// File: tb/test_reloc_guard.sv
`timescale 1ns/1ps
module test_reloc_guard;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sup_mode, cfg_we, req_valid, req_xfer, req_win;
  logic [2:0]  cfg_sel;
  logic [23:0] cfg_wdata;
  logic [17:0] req_addr;
  logic [1:0]  req_kind;
  logic [2:0]  req_char;
  logic        resp_valid, resp_viol;
  logic [17:0] resp_addr;
  logic [2:0]  resp_char;
  logic [1:0]  resp_cause;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  reloc_guard i_reloc_guard (
    .clk(clk), .rst_n(rst_n), .sup_mode(sup_mode), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_kind(req_kind), .req_char(req_char),
    .req_xfer(req_xfer), .req_win(req_win), .resp_valid(resp_valid),
    .resp_addr(resp_addr), .resp_char(resp_char), .resp_viol(resp_viol),
    .resp_cause(resp_cause)
  );

  // bench copy of the control registers, updated from the requirements
  logic [17:0] m_base = '0, m_lo = '0, m_hi = '0;
  logic [18:0] m_size = '0;
  logic [23:0] m_win  = '0;

  typedef struct {
    logic [17:0] addr;
    logic [2:0]  ch;
    logic [1:0]  cause;
    string       tag;
  } exp_t;

  exp_t sb[$];
  exp_t e;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [17:0] a, input logic [1:0] k,
                                 input logic [2:0] c, input logic x, input logic w,
                                 input logic s, input string tag);
    exp_t r;
    int code, lg;
    r.tag   = tag;
    r.ch    = (k == 2'b10) ? c : 3'd0;
    r.cause = 2'd0;
    if (s) begin
      r.addr = a;
    end else if (w) begin
      r.addr = a | m_win[17:0];
      code = int'(m_win[19:18]);
      if (code == 3) r.cause = 2'd1;
      else begin
        lg = 6 + 3 * code;
        if ((a >> lg) != 0) r.cause = 2'd1;
        else if (code == 2 && a[11] && m_win[20 + int'(a[10:9])] && x) r.cause = 2'd3;
      end
    end else begin
      r.addr = a | m_base;
      if ({1'b0, a} >= m_size) r.cause = 2'd1;
      else if (a >= m_lo && a <= m_hi && !x) r.cause = 2'd2;
    end
    return r;
  endfunction

  task automatic cfg(input logic [2:0] sel, input logic [23:0] d, input logic s);
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b1; sup_mode = s; cfg_sel = sel; cfg_wdata = d;
    if (s) begin
      case (sel)
        3'd0: m_base = d[17:0];
        3'd1: m_size = d[18:0];
        3'd2: m_lo   = d[17:0];
        3'd3: m_hi   = d[17:0];
        3'd4: m_win  = d;
        default: ;
      endcase
    end
  endtask

  task automatic req(input logic [17:0] a, input logic [1:0] k, input logic [2:0] c,
                     input logic x, input logic w, input logic s, input string tag);
    @(negedge clk);
    cfg_we = 1'b0; sup_mode = s; req_valid = 1'b1;
    req_addr = a; req_kind = k; req_char = c; req_xfer = x; req_win = w;
    sb.push_back(model(a, k, c, x, w, s, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0; sup_mode = 1'b0;
  endtask

  // monitor: one response per queued item, in order
  always @(negedge clk) begin
    if (resp_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2 unexpected response", 1, 0);
      end else begin
        e = sb.pop_front();
        check(resp_addr == e.addr, {e.tag, " address"}, resp_addr, e.addr);
        check(resp_cause == e.cause, {e.tag, " cause"}, resp_cause, e.cause);
        check(resp_char == e.ch, {e.tag, " char"}, resp_char, e.ch);
        check(resp_viol == (e.cause != 0), "R12 flag", resp_viol, e.cause != 0);
      end
    end
  end

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    rst_n = 1'b0; sup_mode = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; req_kind = '0; req_char = '0;
    req_xfer = 1'b0; req_win = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!resp_valid && resp_addr == 0 && resp_cause == 0 && !resp_viol && resp_char == 0,
          "R1 in reset", resp_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!resp_valid && resp_addr == 0 && resp_cause == 0, "R1 after release", resp_addr, 0);

    cfg(3'd0, 24'h004400, 1'b1);
    cfg(3'd1, 24'h001000, 1'b1);
    cfg(3'd2, 24'h000800, 1'b1);
    cfg(3'd3, 24'h0008FF, 1'b1);
    cfg(3'd4, {4'b0101, 2'd2, 18'h10000}, 1'b1);

    // R3 OR relocation, including overlapping bits
    req(18'h00123, 2'b00, 3'd0, 1'b0, 1'b0, 1'b0, "R3 disjoint bits");
    req(18'h00400, 2'b01, 3'd0, 1'b0, 1'b0, 1'b0, "R3 overlapping bit");
    req(18'h00C00, 2'b00, 3'd0, 1'b0, 1'b0, 1'b0, "R3 partial overlap");
    // R4 limit edges
    req(18'h00FFF, 2'b00, 3'd0, 1'b0, 1'b0, 1'b0, "R4 last word inside");
    req(18'h01000, 2'b00, 3'd0, 1'b0, 1'b0, 1'b0, "R4 first word beyond");
    req(18'h3FFFF, 2'b01, 3'd0, 1'b1, 1'b0, 1'b0, "R4 top address by transfer");
    // R5 sub-region edges
    req(18'h007FF, 2'b00, 3'd0, 1'b0, 1'b0, 1'b0, "R5 below lower bound");
    req(18'h00800, 2'b00, 3'd0, 1'b0, 1'b0, 1'b0, "R5 lower bound");
    req(18'h008FF, 2'b01, 3'd0, 1'b0, 1'b0, 1'b0, "R5 upper bound");
    req(18'h00900, 2'b00, 3'd0, 1'b0, 1'b0, 1'b0, "R5 above upper bound");
    req(18'h00800, 2'b01, 3'd0, 1'b1, 1'b0, 1'b0, "R5 transfer allowed");
    req(18'h00880, 2'b00, 3'd0, 1'b1, 1'b0, 1'b0, "R5 transfer inside");
    idle();
    @(negedge clk);
    check(!resp_valid, "R2 no response after idle", resp_valid, 0);

    // R10: writes in user mode are ignored
    cfg(3'd0, 24'h03FFFF, 1'b0);
    cfg(3'd1, 24'h000000, 1'b0);
    req(18'h00010, 2'b00, 3'd0, 1'b0, 1'b0, 1'b0, "R10 base and size kept");

    // R9 supervisor bypass
    req(18'h3FFFF, 2'b00, 3'd0, 1'b0, 1'b0, 1'b1, "R9 bypass beyond limit");
    req(18'h00800, 2'b01, 3'd0, 1'b0, 1'b0, 1'b1, "R9 bypass in sub-region");

    // R11 character index
    req(18'h00001, 2'b10, 3'd5, 1'b0, 1'b0, 1'b0, "R11 character access");
    req(18'h00001, 2'b00, 3'd5, 1'b0, 1'b0, 1'b0, "R11 word read");
    req(18'h00001, 2'b11, 3'd7, 1'b0, 1'b0, 1'b0, "R11 reserved kind");

    // R6 window lengths
    cfg(3'd4, {4'b0000, 2'd0, 18'h20000}, 1'b1);
    req(18'h0003F, 2'b00, 3'd0, 1'b0, 1'b1, 1'b0, "R6 64-word last");
    req(18'h00040, 2'b00, 3'd0, 1'b0, 1'b1, 1'b0, "R6 64-word beyond");
    cfg(3'd4, {4'b0000, 2'd1, 18'h20010}, 1'b1);
    req(18'h001FF, 2'b00, 3'd0, 1'b0, 1'b1, 1'b0, "R6 512-word last");
    req(18'h00200, 2'b00, 3'd0, 1'b0, 1'b1, 1'b0, "R6 512-word beyond");
    cfg(3'd4, {4'b0000, 2'd2, 18'h21001}, 1'b1);
    req(18'h00FFF, 2'b00, 3'd0, 1'b1, 1'b1, 1'b0, "R6 4096-word last");
    req(18'h01000, 2'b00, 3'd0, 1'b0, 1'b1, 1'b0, "R6 4096-word beyond");
    // R7 reserved length code
    cfg(3'd4, {4'b1111, 2'd3, 18'h00000}, 1'b1);
    req(18'h00000, 2'b00, 3'd0, 1'b0, 1'b1, 1'b0, "R7 reserved code");
    req(18'h00005, 2'b10, 3'd2, 1'b1, 1'b1, 1'b0, "R7 reserved code transfer");

    // R8 every lock pattern against every page
    for (int m = 0; m < 16; m++) begin
      cfg(3'd4, {m[3:0], 2'd2, 18'h04000}, 1'b1);
      for (int p = 0; p < 4; p++) begin
        req(18'(2048 + 512 * p), 2'b01, 3'd0, 1'b1, 1'b1, 1'b0, "R8 transfer page start");
        req(18'(2559 + 512 * p), 2'b01, 3'd0, 1'b1, 1'b1, 1'b0, "R8 transfer page end");
        req(18'(2048 + 512 * p + 7), 2'b00, 3'd0, 1'b0, 1'b1, 1'b0, "R8 processor allowed");
      end
      req(18'h007FF, 2'b01, 3'd0, 1'b1, 1'b1, 1'b0, "R8 below locked pages");
    end
    idle();
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R2 all responses seen", sb.size(), 0);
    finish_up();
  end

endmodule